// File: doc/BRIEF.md
# Prescaled Watchdog Timer

A watchdog timer that sits on a simple 32-bit register bus. The input clock is divided in two stages before it reaches the counter. The first stage is an 8-bit prescaler that divides by its value plus one. The second stage is a fixed divider of 16, 32, 64 or 128. Each tick from this chain decrements a 16-bit counter. Software services the watchdog by writing a fresh value straight into the count register. If software stops doing so, the counter reaches zero.

When the counter reaches zero, the block raises a sticky interrupt, drives a reset pulse of fixed length, or does both. Each action has its own enable bit. On the next tick the counter reloads from the reload register and keeps running. A write of 1 to the clear register drops the interrupt.

Top module: `wdog_timer`

## Requirements
- R1: After rst_ni is released, the control register reads 0, the reload and count registers read 0x0000FFFF, and irq_o and rst_o are low.
- R2: The control register (offset 0x0 on addr_i) keeps bit 0 (reset enable), bit 2 (interrupt enable), bits 4:3 (divider select), bit 5 (run) and bits 15:8 (prescaler P), and reads all other bits as 0. The reload register (offset 0x4) keeps bits 15:0 and reads its upper bits as 0.
- R3: While control bit 5 is 0, the counter holds its value, whatever the other control bits are.
- R4: While running, the counter decrements once every (P+1)*D input clocks. D is 16, 32, 64 or 128 for divider select 00, 01, 10 or 11. The first decrement comes (P+1)*D clocks after the write that sets the run bit.
- R5: A write to offset 0x8 loads wdata_i[15:0] into the counter on that clock edge, whether or not the counter is running. Reads of offset 0x8 return the live count.
- R6: A tick that finds the counter at 0 loads the reload register value, and counting goes on.
- R7: A tick that takes the counter from 1 to 0 with interrupt enable set drives irq_o high. irq_o stays high until a write to offset 0xC with wdata_i[0]=1. A write to 0xC with wdata_i[0]=0 leaves it high.
- R8: A tick that takes the counter from 1 to 0 with reset enable set drives rst_o high for exactly 128 clocks, starting the clock after that tick.
- R9: With both enables clear, the counter reaching 0 leaves irq_o and rst_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Expiry interrupt, level |
| rst_o | output | 1 | System reset request pulse |

## Verification
The hardest cases to reach are the exact cycle of the first decrement and the exact cycle of the expiry. Both depend on the phase of the hidden two-stage timebase. The bench gets there by starting every timed scenario from the run-bit write, with the timebase cleared by a prior stop. It then counts clocks to land a read on the last cycle before a tick and on the first cycle after it. The reset pulse is measured the same way at both of its edges. A reload of 0xFFFF keeps a second expiry from starting during that measurement.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int PRE_W = 8;
  localparam int SEL_W = 2;
  localparam logic [3:0] OFF_CTRL   = 4'h0;
  localparam logic [3:0] OFF_RELOAD = 4'h4;
  localparam logic [3:0] OFF_COUNT  = 4'h8;
  localparam logic [3:0] OFF_CLEAR  = 4'hC;

  typedef struct packed {
    logic [PRE_W-1:0] presc;
    logic [SEL_W-1:0] div_sel;
    logic             run;
    logic             irq_en;
    logic             rst_en;
  } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic wr;
  assign wr         = req_i & we_i;
  assign load_o     = wr && addr_i == OFF_COUNT;
  assign load_val_o = wdata_i[CNT_W-1:0];
  assign clr_o      = wr && addr_i == OFF_CLEAR && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o   <= '0;
      reload_o <= '1;
    end else if (wr) begin
      if (addr_i == OFF_CTRL) begin
        ctrl_o.presc   <= wdata_i[8 +: PRE_W];
        ctrl_o.div_sel <= wdata_i[3 +: SEL_W];
        ctrl_o.run     <= wdata_i[5];
        ctrl_o.irq_en  <= wdata_i[2];
        ctrl_o.rst_en  <= wdata_i[0];
      end
      if (addr_i == OFF_RELOAD) reload_o <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_CTRL: begin
        rdata_o[8 +: PRE_W] = ctrl_o.presc;
        rdata_o[5]          = ctrl_o.run;
        rdata_o[3 +: SEL_W] = ctrl_o.div_sel;
        rdata_o[2]          = ctrl_o.irq_en;
        rdata_o[0]          = ctrl_o.rst_en;
      end
      OFF_RELOAD: rdata_o[CNT_W-1:0] = reload_o;
      OFF_COUNT:  rdata_o[CNT_W-1:0] = cnt_i;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdog_tick.sv
module wdog_tick
  import wdog_pkg::*;
#(
  parameter int BASE_DIV = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] presc_i,
  input  logic [SEL_W-1:0] div_sel_i,
  output logic             tick_o
);
  localparam int MAX_DIV = BASE_DIV << ((1 << SEL_W) - 1);
  localparam int DIV_W   = $clog2(MAX_DIV);

  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt, div_last;
  logic             pre_hit, div_hit;

  always_comb div_last = DIV_W'((BASE_DIV << div_sel_i) - 1);

  // >= keeps the chain bounded if the fields shrink mid-run
  assign pre_hit = pre_cnt >= presc_i;
  assign div_hit = div_cnt >= div_last;
  assign tick_o  = run_i & pre_hit & div_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (!run_i) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (pre_hit) begin
      pre_cnt <= '0;
      div_cnt <= div_hit ? '0 : div_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  assert_tick_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  assert_stop_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> pre_cnt == '0 && div_cnt == '0);
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int CNT_W      = 16,
  parameter int RST_CYCLES = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             irq_en_i,
  input  logic             rst_en_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             rst_o
);
  localparam int RST_W = $clog2(RST_CYCLES + 1);

  logic [RST_W-1:0] rst_cnt;
  logic             expire;

  assign expire = tick_i && !load_i && cnt_o == CNT_W'(1);
  assign rst_o  = rst_cnt != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o   <= '1;
      irq_o   <= 1'b0;
      rst_cnt <= '0;
    end else begin
      if (load_i)      cnt_o <= load_val_i;
      else if (tick_i) cnt_o <= (cnt_o == '0) ? reload_i : cnt_o - 1'b1;

      if (expire && irq_en_i) irq_o <= 1'b1;
      else if (clr_i)         irq_o <= 1'b0;

      if (expire && rst_en_i) rst_cnt <= RST_W'(RST_CYCLES);
      else if (rst_o)         rst_cnt <= rst_cnt - 1'b1;
    end
  end

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !load_i |=> $stable(cnt_o));
  assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_o == $past(load_val_i));
  assert_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !load_i && cnt_o == '0 |=> cnt_o == $past(reload_i));
  assert_irq_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr_i |=> irq_o);
  assert_rst_len_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o && !(expire && rst_en_i) |=> rst_cnt == $past(rst_cnt) - 1'b1);
  assert_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o && !(expire && irq_en_i) |=> !irq_o);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 32,
  parameter int BASE_DIV   = 16,
  parameter int RST_CYCLES = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              rst_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, load_val, cnt;
  logic             load, clr, tick;

  wdog_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .cnt_i(cnt), .ctrl_o(ctrl), .reload_o(reload), .load_o(load),
    .load_val_o(load_val), .clr_o(clr), .rdata_o
  );

  wdog_tick #(.BASE_DIV(BASE_DIV)) u_tick (
    .clk_i, .rst_ni, .run_i(ctrl.run), .presc_i(ctrl.presc),
    .div_sel_i(ctrl.div_sel), .tick_o(tick)
  );

  wdog_core #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_core (
    .clk_i, .rst_ni, .tick_i(tick), .load_i(load), .load_val_i(load_val),
    .reload_i(reload), .irq_en_i(ctrl.irq_en), .rst_en_i(ctrl.rst_en),
    .clr_i(clr), .cnt_o(cnt), .irq_o, .rst_o
  );
endmodule

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;
  localparam logic [3:0] A_CTRL = 4'h0, A_RLD = 4'h4, A_CNT = 4'h8, A_CLR = 4'hC;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, rst_req;
  int          n_run = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #10 clk = ~clk;

  wdog_timer u_wdog_timer (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .rst_o(rst_req)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data at the middle of each read cycle
  always @(negedge clk) begin
    if (req && !we) begin
      if (exp_q.size() == 0) chk(rdata, 32'hx, "scoreboard underflow");
      else chk(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(1);
    // R1 reset state
    chk({31'b0, irq}, 0, "R1 irq");
    chk({31'b0, rst_req}, 0, "R1 rst");
    rd(A_CTRL, 32'h0, "R1 ctrl");
    rd(A_RLD, 32'h0000_FFFF, "R1 reload");
    rd(A_CNT, 32'h0000_FFFF, "R1 count");
    // R2 readback with run off
    wr(A_CTRL, 32'hFFFF_FFDF);
    rd(A_CTRL, 32'h0000_FF1D, "R2 ctrl fields");
    wr(A_RLD, 32'h1234_ABCD);
    rd(A_RLD, 32'h0000_ABCD, "R2 reload");
    rd(A_CLR, 32'h0, "R2 clear reads zero");
    // R3 hold with enables set but run clear
    wr(A_CTRL, 32'h0000_0005);
    wr(A_CNT, 32'd50);
    wait_clk(300);
    rd(A_CNT, 32'd50, "R3 hold");
    // R5 direct load
    wr(A_CNT, 32'hDEAD_1234);
    rd(A_CNT, 32'h0000_1234, "R5 load");
    // R4 P=1 D=16 -> 32 clocks
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'd100);
    wr(A_CTRL, 32'h0000_0120);
    wait_clk(31);
    rd(A_CNT, 32'd100, "R4 before tick p1d16");
    rd(A_CNT, 32'd99, "R4 after tick p1d16");
    // R4 P=2 D=32 -> 96 clocks
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'd100);
    wr(A_CTRL, 32'h0000_0228);
    wait_clk(95);
    rd(A_CNT, 32'd100, "R4 before tick p2d32");
    rd(A_CNT, 32'd99, "R4 after tick p2d32");
    // R6/R7 expiry with interrupt, period 16
    wr(A_CTRL, 32'h0);
    wr(A_RLD, 32'd5);
    wr(A_CNT, 32'd2);
    wr(A_CTRL, 32'h0000_0024);
    wait_clk(31);
    chk({31'b0, irq}, 0, "R7 irq before expiry");
    rd(A_CNT, 32'd1, "R7 count before expiry");
    chk({31'b0, irq}, 1, "R7 irq at expiry");
    chk({31'b0, rst_req}, 0, "R8 rst disabled");
    rd(A_CNT, 32'd0, "R7 count zero");
    wait_clk(15);
    rd(A_CNT, 32'd5, "R6 reload");
    wr(A_CTRL, 32'h0);
    chk({31'b0, irq}, 1, "R7 sticky");
    wr(A_CLR, 32'h0);
    chk({31'b0, irq}, 1, "R7 clear with 0 ignored");
    wr(A_CLR, 32'h1);
    chk({31'b0, irq}, 0, "R7 cleared");
    // R8 reset pulse length
    wr(A_RLD, 32'h0000_FFFF);
    wr(A_CNT, 32'd1);
    wr(A_CTRL, 32'h0000_0021);
    wait_clk(15);
    chk({31'b0, rst_req}, 0, "R8 before expiry");
    wait_clk(1);
    chk({31'b0, rst_req}, 1, "R8 first cycle");
    chk({31'b0, irq}, 0, "R9 irq disabled");
    wait_clk(127);
    chk({31'b0, rst_req}, 1, "R8 last cycle");
    wait_clk(1);
    chk({31'b0, rst_req}, 0, "R8 after pulse");
    // R9 no action enabled
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'd1);
    wr(A_CTRL, 32'h0000_0020);
    wait_clk(20);
    rd(A_CNT, 32'd0, "R9 count reached zero");
    chk({31'b0, irq}, 0, "R9 irq low");
    chk({31'b0, rst_req}, 0, "R9 rst low");
    wr(A_CTRL, 32'h0);
    wait_clk(2);
    if (exp_q.size() != 0) chk(exp_q.size(), 0, "scoreboard drained");
    done = 1'b1;
    finish_run();
  end
endmodule